// File: doc/BRIEF.md
# Delta-Sigma Converter Frame Reader

This block sits on the host side of a three-wire serial link to a delta-sigma converter. It lowers chip select, lets the line settle for a set number of cycles, then looks at the data line. The converter drives its end-of-conversion flag onto that line as a live level. A high level means the conversion is still running. In that case the reader releases chip select, waits a set poll interval and tries again. A low level means a result is ready. The reader then generates 32 serial clock periods and shifts in one bit on each rising edge, most-significant bit first.

When the frame is complete, the reader raises chip select again and decodes the frame. The frame holds a dummy bit that must be zero, a sign bit, a 24-bit result and five bits below the result's LSB. The sign bit and the result's top bit together encode the out-of-range conditions, and the reader turns them into separate overrange and underrange flags. It also forms a 25-bit two's-complement value. All outputs are updated together and marked by a one-cycle valid pulse. A system that needs continuous readings holds the run input high.

Top module: `adc_frame_reader`

## Requirements
- R1: After reset, chip select is high (inactive), the serial clock is low and the valid output is low; with run low the reader stays in that state.
- R2: After chip select falls, the reader holds it low for exactly SETTLE system clock cycles and then samples the data line. If the line is high (conversion busy), chip select rises without any serial clock edge and stays high for at least POLL_GAP cycles before the next attempt.
- R3: If the sampled line is low, exactly 32 serial clock rising edges occur while chip select is low, and the serial clock only toggles while chip select is low.
- R4: The serial clock high phase and low phase each last HALF_DIV system clock cycles.
- R5: Frame bits are captured on serial clock rising edges, first bit received = frame bit 31. The result output equals frame bits 28..5 and the sub-LSB output equals frame bits 4..0.
- R6: Overrange is set when frame bits 29 and 28 are both 1; underrange is set when both are 0; otherwise both flags are 0.
- R7: The framing-error flag is set when frame bit 30 (the dummy bit) or frame bit 31 (the end-of-conversion bit) was captured as 1.
- R8: The signed output is {~bit29, bits 28..5} read as a 25-bit two's-complement number. For example, sign 1 with result 0x000123 gives +0x123, and sign 0 with result 0xFFFF00 gives -256.
- R9: Valid is a single-cycle pulse, and the decoded outputs change only in a cycle in which valid is high.
- R10: Chip select is already high in the cycle in which valid is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Keep polling and reading frames while high |
| cs_n | output | 1 | Converter chip select, active low |
| sclk | output | 1 | Serial clock to the converter |
| sdi | input | 1 | Serial data from the converter |
| res_valid | output | 1 | One-cycle pulse: decoded outputs updated |
| res_signed | output | 25 | Two's-complement conversion value |
| res_code | output | 24 | Raw 24-bit result field |
| res_sub | output | 5 | Sub-LSB bits |
| res_over | output | 1 | Input above positive full scale |
| res_under | output | 1 | Input below negative full scale |
| res_frame_err | output | 1 | Dummy or end-of-conversion bit captured high |

## Verification
The bench reads frames from a converter model that changes data on falling edges. The frames include a positive and a negative result, zero, the most negative in-range value, both out-of-range codes and a frame with the dummy bit set.

- An inverted sign bit would show up as a wrong signed value.
- A capture on the falling edge, or one edge too many or too few, would shift every field by one bit.
- Swapped range decoding would raise the wrong flag.

With the converter held busy, the bench checks that no serial clock edge appears, and it checks the settle time and the poll spacing. A reader that ignored the ready level would clock out garbage frames and report them as valid.

// File: rtl/adc_frame_reader.sv
module adc_frame_reader #(
  parameter int HALF_DIV = 2,
  parameter int SETTLE   = 3,
  parameter int POLL_GAP = 20,
  parameter int CNT_W    = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        run,
  output logic        cs_n,
  output logic        sclk,
  input  logic        sdi,
  output logic        res_valid,
  output logic [24:0] res_signed,
  output logic [23:0] res_code,
  output logic [4:0]  res_sub,
  output logic        res_over,
  output logic        res_under,
  output logic        res_frame_err
);

  localparam int FRAME = 32;
  localparam int BCW   = $clog2(FRAME + 1);
  localparam logic [CNT_W-1:0] SETTLE_END = CNT_W'(SETTLE - 1);
  localparam logic [CNT_W-1:0] HALF_END   = CNT_W'(HALF_DIV - 1);
  localparam logic [CNT_W-1:0] GAP_END    = CNT_W'(POLL_GAP - 1);
  localparam logic [BCW-1:0]   NB_END     = BCW'(FRAME);

  typedef enum logic [2:0] {S_IDLE, S_SETTLE, S_SHIFT, S_DONE, S_GAP} st_t;

  st_t              st;
  logic [CNT_W-1:0] cnt;
  logic [BCW-1:0]   nbit;
  logic [FRAME-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st            <= S_IDLE;
      cs_n          <= 1'b1;
      sclk          <= 1'b0;
      cnt           <= '0;
      nbit          <= '0;
      sh            <= '0;
      res_valid     <= 1'b0;
      res_signed    <= '0;
      res_code      <= '0;
      res_sub       <= '0;
      res_over      <= 1'b0;
      res_under     <= 1'b0;
      res_frame_err <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      case (st)
        S_IDLE: if (run) begin
          cs_n <= 1'b0;
          cnt  <= '0;
          st   <= S_SETTLE;
        end
        S_SETTLE: if (cnt == SETTLE_END) begin
          cnt <= '0;
          if (sdi) begin
            cs_n <= 1'b1;
            st   <= S_GAP;
          end else begin
            nbit <= '0;
            st   <= S_SHIFT;
          end
        end else cnt <= cnt + 1'b1;
        S_SHIFT: if (cnt == HALF_END) begin
          cnt  <= '0;
          sclk <= ~sclk;
          if (!sclk) begin
            sh   <= {sh[FRAME-2:0], sdi};
            nbit <= nbit + 1'b1;
          end else if (nbit == NB_END) begin
            st <= S_DONE;
          end
        end else cnt <= cnt + 1'b1;
        S_DONE: begin
          cs_n          <= 1'b1;
          res_valid     <= 1'b1;
          res_signed    <= {~sh[29], sh[28:5]};
          res_code      <= sh[28:5];
          res_sub       <= sh[4:0];
          res_over      <= sh[29] & sh[28];
          res_under     <= ~sh[29] & ~sh[28];
          res_frame_err <= sh[31] | sh[30];
          cnt           <= '0;
          st            <= S_GAP;
        end
        S_GAP: if (cnt == GAP_END) begin
          cnt <= '0;
          st  <= S_IDLE;
        end else cnt <= cnt + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  logic           sclk_d;
  logic [BCW-1:0] rises;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      rises  <= '0;
    end else begin
      sclk_d <= sclk;
      if (cs_n) rises <= '0;
      else if (sclk && !sclk_d) rises <= rises + 1'b1;
    end
  end

  a_r3_sclk_only_selected: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> !cs_n);
  a_r3_full_frame: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> rises == NB_END);
  a_r2_gap_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_GAP) |-> (cs_n && !sclk));
  a_r6_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(res_over && res_under));
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);
  a_r9_hold_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> ($stable(res_signed) && $stable(res_over) && $stable(res_under)));
  a_r10_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> cs_n);

endmodule

// File: tb/sim_adc_frame_reader.sv
module sim_adc_frame_reader;
  localparam int HALF_DIV = 2;
  localparam int SETTLE   = 3;
  localparam int POLL_GAP = 20;
  localparam int NV = 7;

  localparam logic [31:0] FR [NV] = '{
    32'h2000247B, 32'h1FFFE004, 32'h30000000, 32'h0FFFFFFF,
    32'h600014A2, 32'h20000000, 32'h10000000};
  localparam logic [24:0] EXP_S [NV] = '{
    25'h0000123, 25'h1FFFF00, 25'h0800000, 25'h17FFFFF,
    25'h00000A5, 25'h0000000, 25'h1800000};
  localparam logic [2:0] EXP_F [NV] = '{   // {over, under, frame_err}
    3'b000, 3'b000, 3'b100, 3'b010, 3'b001, 3'b000, 3'b000};

  logic clk = 1'b0, rst_n = 1'b0, run = 1'b0;
  logic cs_n, sclk, sdi, res_valid, res_over, res_under, res_frame_err;
  logic [24:0] res_signed;
  logic [23:0] res_code;
  logic [4:0]  res_sub;

  always #10 clk = ~clk;

  adc_frame_reader #(.HALF_DIV(HALF_DIV), .SETTLE(SETTLE), .POLL_GAP(POLL_GAP)) u0 (
    .clk(clk), .rst_n(rst_n), .run(run), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .res_valid(res_valid), .res_signed(res_signed), .res_code(res_code),
    .res_sub(res_sub), .res_over(res_over), .res_under(res_under),
    .res_frame_err(res_frame_err));

  logic [31:0] frame = 32'h0;
  logic        ready = 1'b1;
  int          idx = 31;
  always @(negedge sclk or posedge cs_n)
    if (cs_n) idx <= 31;
    else if (idx > 0) idx <= idx - 1;
  assign sdi = (cs_n || !ready) ? 1'b1 : frame[idx[4:0]];

  int sclk_rises = 0, cs_falls = 0, vcount = 0;
  always @(posedge sclk) sclk_rises++;
  always @(negedge cs_n) cs_falls++;
  always @(posedge clk) if (res_valid) vcount++;

  int tests = 0, fails = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_valid();
    do @(negedge clk); while (!res_valid);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_n == 1'b1, "R1 cs_n in reset", 32'(cs_n), 32'd1);
    chk(sclk == 1'b0, "R1 sclk in reset", 32'(sclk), 32'd0);
    chk(res_valid == 1'b0, "R1 valid in reset", 32'(res_valid), 32'd0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(cs_n == 1'b1 && sclk_rises == 0, "R1 idle with run low", 32'(cs_n), 32'd1);

    for (int i = 0; i < NV; i++) begin
      frame = FR[i];
      ready = 1'b1;
      sclk_rises = 0;
      run = 1'b1;
      wait_valid();
      run = 1'b0;
      chk(res_signed == EXP_S[i], "R8 signed value", 32'(res_signed), 32'(EXP_S[i]));
      chk(res_code == FR[i][28:5], "R5 result field", 32'(res_code), 32'(FR[i][28:5]));
      chk(res_sub == FR[i][4:0], "R5 sub-LSB field", 32'(res_sub), 32'(FR[i][4:0]));
      chk({res_over, res_under} == EXP_F[i][2:1], "R6 range flags",
          32'({res_over, res_under}), 32'(EXP_F[i][2:1]));
      chk(res_frame_err == EXP_F[i][0], "R7 framing error", 32'(res_frame_err), 32'(EXP_F[i][0]));
      chk(sclk_rises == 32, "R3 clock edges per frame", 32'(sclk_rises), 32'd32);
      chk(cs_n == 1'b1, "R10 cs_n high at valid", 32'(cs_n), 32'd1);
      @(negedge clk);
      chk(res_valid == 1'b0, "R9 valid single cycle", 32'(res_valid), 32'd0);
      chk(res_signed == EXP_S[i], "R9 outputs held", 32'(res_signed), 32'(EXP_S[i]));
      repeat (POLL_GAP + 10) @(negedge clk);
    end

    // busy converter: polling only
    ready = 1'b0;
    frame = FR[0];
    sclk_rises = 0;
    cs_falls = 0;
    begin
      int v0, n;
      v0 = vcount;
      run = 1'b1;
      do @(negedge clk); while (cs_n);
      n = 0;
      while (!cs_n) begin n++; @(negedge clk); end
      chk(n == SETTLE, "R2 settle length", 32'(n), 32'(SETTLE));
      repeat (190) @(negedge clk);
      chk(sclk_rises == 0, "R2 no clock while busy", 32'(sclk_rises), 32'd0);
      chk(cs_falls >= 7 && cs_falls <= 9, "R2 poll spacing", 32'(cs_falls), 32'd8);
      chk(vcount == v0, "R2 no valid while busy", 32'(vcount), 32'(v0));
    end

    // converter becomes ready between polls
    do @(negedge clk); while (!cs_n);
    ready = 1'b1;
    sclk_rises = 0;
    begin
      int h, l;
      do @(negedge clk); while (!sclk);
      h = 0;
      while (sclk) begin h++; @(negedge clk); end
      l = 0;
      while (!sclk) begin l++; @(negedge clk); end
      chk(h == HALF_DIV, "R4 high phase", 32'(h), 32'(HALF_DIV));
      chk(l == HALF_DIV, "R4 low phase", 32'(l), 32'(HALF_DIV));
    end
    wait_valid();
    run = 1'b0;
    chk(res_signed == EXP_S[0], "R2 read after ready", 32'(res_signed), 32'(EXP_S[0]));
    chk(sclk_rises == 32, "R3 edges after poll", 32'(sclk_rises), 32'd32);

    repeat (40) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule